// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block is the command front end of a serial flash device for erase operations. It watches a mode-0 SPI-style link (active-low select, serial clock, data in, data out), which it samples with its own system clock. It takes in an opcode and a 24-bit address and decides, only when select returns high, whether an erase may begin. An accepted erase produces a one-cycle start strobe toward the array. The strobe carries the region base, with the don't-care low bits forced to zero, and a size code. A self-timed busy interval then follows, with a length set by a per-size parameter.

The block keeps a small status byte: ready/busy, the write-enable latch and a sticky erase-error flag fed by the array. A host sets the latch with a one-byte command and reads the status byte with a read command at any time, including during an erase. Every rejected erase is silent. No strobe is issued, and the latch is cleared.

Top module: `sfe_erase_dec`

## Requirements
- R1: Opcode 06h, closed on a byte boundary while not busy, sets the write-enable latch. Bits are taken on rising serial-clock edges, MSB first.
- R2: Opcode 05h shifts the status byte out MSB first on `miso`, with busy at bit 0, the latch at bit 1 and erase error at bit 5 (all other bits 0). It also works while busy.
- R3: Opcode 81h erases a 256-byte page. `erase_addr` holds first-address-byte bits 2..0 as address bits 18..16 and the second byte as bits 15..8. Bits 7..0 are zero and `erase_size` is 0.
- R4: Opcodes 20h, 52h and D8h erase 4 KB, 32 KB and 64 KB regions. They give `erase_size` 1, 2 and 3, and clear address bits 11..0, 14..0 and 15..0 respectively.
- R5: `erase_go` is a single-cycle pulse that appears only on the clock after `cs_n` goes high, never while select is low.
- R6: An erase with fewer than three address bytes is dropped, and the latch is cleared.
- R7: An erase whose bit count at select release is not a multiple of eight is dropped, and the latch is cleared.
- R8: An erase is dropped when the write-enable latch is clear.
- R9: An erase into a region whose 64 KB sector bit in `wp_sect` is set (the index is address bits 18..16) is dropped, and the latch is cleared.
- R10: Bytes sent after the third address byte do not change the erase.
- R11: `erase_busy` rises with `erase_go` and stays high for exactly the size's cycle parameter. The latch is clear from the start of the erase.
- R12: `erase_fail` high during busy sets the error bit. The bit stays set until the next erase starts.
- R13: While busy, no command other than 05h has any effect: no erase starts and the latch is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out (status) |
| wp_sect | input | 2**(AW-16) | Per-64 KB-sector protection |
| erase_fail | input | 1 | Array reports a failed location |
| erase_go | output | 1 | Erase start strobe |
| erase_addr | output | AW | Aligned region base |
| erase_size | output | 2 | 0 page, 1 4 KB, 2 32 KB, 3 64 KB |
| erase_busy | output | 1 | Erase interval in progress |

## Verification
Two functions can meet in one cycle: the status read can run while the busy timer is counting, and an incoming command can close while an erase is still busy. The bench reads status mid-erase and expects busy set with the latch already clear. It also sends a latch-set command during the busy interval and then expects the latch to read clear once the erase is over. An array failure pulse injected mid-erase must show up in the status after completion, and the next accepted erase must clear it.

// File: rtl/sfe_erase_dec.sv
module sfe_erase_dec #(
  parameter int AW     = 19,
  parameter int TW     = 25,
  parameter int T_PAGE = 800_000,
  parameter int T_4K   = 2_000_000,
  parameter int T_32K  = 12_000_000,
  parameter int T_64K  = 30_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    mosi,
  output logic                    miso,
  input  logic [2**(AW-16)-1:0]   wp_sect,
  input  logic                    erase_fail,
  output logic                    erase_go,
  output logic [AW-1:0]           erase_addr,
  output logic [1:0]              erase_size,
  output logic                    erase_busy
);
  localparam int SW = AW - 16;

  logic          sck_q, cs_q;
  logic [5:0]    cnt;
  logic [22:0]   sh;
  logic [7:0]    op;
  logic [23:0]   adr;
  logic          wel, epe;
  logic [TW-1:0] tmr;
  logic [1:0]    sz;
  logic [AW-1:0] msk;
  logic [TW-1:0] tload;

  wire sck_rise = !cs_n && sck && !sck_q;
  wire cs_rise  = cs_n && !cs_q;
  wire has_op   = cnt >= 6'd8;
  wire aligned  = cnt[2:0] == 3'd0;
  wire is_erase = has_op && (op == 8'h81 || op == 8'h20 || op == 8'h52 || op == 8'hD8);
  wire full     = cnt >= 6'd32 && aligned;
  wire [SW-1:0] sect = adr[AW-1:16];
  wire go_ok    = is_erase && full && wel && !wp_sect[sect] && !erase_busy;
  wire wren_ok  = has_op && aligned && op == 8'h06 && !erase_busy;
  wire [7:0] stat = {2'b00, epe, 3'b000, wel, erase_busy};

  assign miso = (has_op && op == 8'h05) ? stat[~cnt[2:0]] : 1'b0;

  always_comb begin
    case (op)
      8'h20:   sz = 2'd1;
      8'h52:   sz = 2'd2;
      8'hD8:   sz = 2'd3;
      default: sz = 2'd0;
    endcase
    case (sz)
      2'd1:    begin msk = AW'(16'h0FFF); tload = TW'(T_4K - 1);   end
      2'd2:    begin msk = AW'(16'h7FFF); tload = TW'(T_32K - 1);  end
      2'd3:    begin msk = AW'(16'hFFFF); tload = TW'(T_64K - 1);  end
      default: begin msk = AW'(16'h00FF); tload = TW'(T_PAGE - 1); end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt   <= '0;
      sh    <= '0;
      op    <= '0;
      adr   <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        cnt <= '0;
      end else if (sck_rise) begin
        cnt <= (cnt == 6'd39) ? 6'd32 : cnt + 6'd1;
        if (cnt < 6'd32) sh <= {sh[21:0], mosi};
        if (cnt == 6'd7)  op  <= {sh[6:0], mosi};
        if (cnt == 6'd31) adr <= {sh, mosi};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel        <= 1'b0;
      epe        <= 1'b0;
      tmr        <= '0;
      erase_busy <= 1'b0;
      erase_go   <= 1'b0;
      erase_addr <= '0;
      erase_size <= '0;
    end else begin
      erase_go <= 1'b0;
      if (cs_rise && go_ok) begin
        erase_go   <= 1'b1;
        erase_addr <= adr[AW-1:0] & ~msk;
        erase_size <= sz;
        erase_busy <= 1'b1;
        tmr        <= tload;
        wel        <= 1'b0;
        epe        <= 1'b0;
      end else begin
        if (cs_rise && is_erase && !erase_busy) wel <= 1'b0;
        if (cs_rise && wren_ok) wel <= 1'b1;
        if (erase_busy) begin
          if (erase_fail) epe <= 1'b1;
          if (tmr == '0) erase_busy <= 1'b0;
          else tmr <= tmr - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfe_erase_dec_chk.sv
module sfe_erase_dec_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          erase_go,
  input logic [AW-1:0] erase_addr,
  input logic [1:0]    erase_size,
  input logic          erase_busy
);
  logic [AW-1:0] low;
  always_comb begin
    case (erase_size)
      2'd1:    low = AW'(16'h0FFF);
      2'd2:    low = AW'(16'h7FFF);
      2'd3:    low = AW'(16'hFFFF);
      default: low = AW'(16'h00FF);
    endcase
  end

  AST_GO_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> $past(cs_n)); // R5
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) erase_go |=> !erase_go); // R5
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> (erase_addr & low) == '0); // R4
  AST_BUSY_STARTS_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n) $rose(erase_busy) |-> erase_go); // R11
  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> !$past(erase_busy)); // R13
endmodule

bind sfe_erase_dec sfe_erase_dec_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .erase_go(erase_go),
  .erase_addr(erase_addr), .erase_size(erase_size), .erase_busy(erase_busy)
);

// File: tb/sfe_erase_dec_tb_top.sv
module sfe_erase_dec_tb_top;
  localparam int AW = 19;
  localparam int TP = 150, T4 = 200, T32 = 250, T64 = 300;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, erase_fail = 0;
  logic [7:0] wp_sect = '0;
  logic miso, erase_go, erase_busy;
  logic [AW-1:0] erase_addr;
  logic [1:0] erase_size;

  int n_chk = 0, n_fail = 0;
  int run = 0, last_len = 0;
  logic [AW+1:0] expq [$];

  always #2.5 clk = ~clk;

  sfe_erase_dec #(.AW(AW), .TW(12), .T_PAGE(TP), .T_4K(T4), .T_32K(T32), .T_64K(T64)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .wp_sect(wp_sect), .erase_fail(erase_fail), .erase_go(erase_go),
    .erase_addr(erase_addr), .erase_size(erase_size), .erase_busy(erase_busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && erase_go) begin
      if (expq.size() == 0) check("R5 unexpected erase strobe", {erase_size, erase_addr}, '1);
      else check("R3/R4 scoreboard strobe", {erase_size, erase_addr}, expq.pop_front());
    end
    if (erase_busy) run++;
    else if (run != 0) begin last_len = run; run = 0; end
  end

  task automatic bitx(input logic b, output logic r);
    @(negedge clk) sck = 0; mosi = b;
    repeat (2) @(negedge clk);
    r = miso; sck = 1;
    repeat (2) @(negedge clk);
    sck = 0;
  endtask

  task automatic bytex(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bitx(b[i], r[i]);
  endtask

  task automatic sel;   @(negedge clk) cs_n = 0; repeat (2) @(negedge clk); endtask
  task automatic desel; repeat (2) @(negedge clk); cs_n = 1; repeat (3) @(negedge clk); endtask

  task automatic wren;
    logic [7:0] d;
    sel; bytex(8'h06, d); desel;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel; bytex(8'h05, d); bytex(8'h00, s); desel;
  endtask

  task automatic erase(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                       input int xbits, input logic expect_go, input logic [AW+1:0] exp);
    logic [7:0] d; logic r;
    if (expect_go) expq.push_back(exp);
    sel; bytex(op, d);
    for (int i = 0; i < nbytes; i++) bytex(i < 3 ? a[23-8*i -: 8] : 8'hA5, d);
    for (int i = 0; i < xbits; i++) bitx(1'b1, r);
    desel;
  endtask

  task automatic wait_idle;
    while (erase_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    check("watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("reset go/busy", {erase_go, erase_busy}, 0);
    rdsr(s); check("R2 reset status", s, 8'h00);

    wren; rdsr(s); check("R1 latch set, R2 bit1", s, 8'h02);

    erase(8'h81, 24'hF5ABCD, 3, 0, 1, {2'd0, 19'h5AB00});
    rdsr(s); check("R2/R11 status during busy", s, 8'h01);
    wait_idle; check("R11 page busy length", last_len, TP);
    rdsr(s); check("R2 idle after page", s, 8'h00);

    wp_sect = 8'b0000_0100;
    wren; erase(8'h20, 24'h034FFF, 3, 0, 1, {2'd1, 19'h34000});
    wait_idle; check("R11 4K busy length", last_len, T4);

    wren; erase(8'h20, 24'h021000, 3, 0, 0, '0);
    rdsr(s); check("R9 protected abort clears latch", s, 8'h00);
    check("R9 no busy", erase_busy, 0);
    wp_sect = '0;

    wren; erase(8'h52, 24'h01FFFF, 3, 0, 1, {2'd2, 19'h18000});
    wait_idle; check("R11 32K busy length", last_len, T32);

    wren; erase(8'hD8, 24'h071234, 5, 0, 1, {2'd3, 19'h70000});
    wait_idle; check("R10/R11 64K busy length", last_len, T64);

    erase(8'hD8, 24'h050000, 3, 0, 0, '0);
    check("R8 no latch no busy", erase_busy, 0);

    wren; erase(8'h20, 24'h010000, 2, 0, 0, '0);
    rdsr(s); check("R6 short address clears latch", s, 8'h00);

    wren; erase(8'h20, 24'h010000, 3, 3, 0, '0);
    rdsr(s); check("R7 unaligned clears latch", s, 8'h00);

    wren; erase(8'h81, 24'h000300, 3, 0, 1, {2'd0, 19'h00300});
    repeat (10) @(negedge clk); erase_fail = 1; @(negedge clk); erase_fail = 0;
    wren;
    erase(8'h20, 24'h020000, 3, 0, 0, '0);
    wait_idle;
    rdsr(s); check("R12/R13 error set, latch stays clear", s, 8'h20);

    wren; erase(8'h81, 24'h000100, 3, 0, 1, {2'd0, 19'h00100});
    rdsr(s); check("R12 error cleared at next start", s, 8'h01);
    wait_idle;

    check("R5 scoreboard drained", expq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule